// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame should be kept, based only on its 48-bit destination address. The six address bytes arrive one per valid cycle, first byte first. While they stream in, the block folds them into a CRC-32 and assembles the address. When the sixth byte arrives, it combines several inputs into a single accept or reject verdict: the configured modes, a 64-bin multicast hash table and a small table of exact unicast addresses.

The modes are static configuration inputs: a promiscuous switch, a pass-every-multicast switch and a hash-multicast enable. The 64-bit hash table arrives as a low and a high 32-bit word. The unicast table is loaded through a simple one-entry-per-cycle write port. Each entry carries its own valid flag.

Top module: `daf_filter`

## Requirements
- R1: After reset `done_o` and `accept_o` are 0, and every unicast table entry is invalid.
- R2: `done_o` pulses high for exactly one cycle, in the cycle after the clock edge that captures the sixth address byte. `accept_o` is 0 whenever `done_o` is 0.
- R3: With `cfg_promisc_i` set, every address is accepted.
- R4: The all-ones broadcast address is always accepted.
- R5: An address is multicast when bit 0 of its first byte is 1. With `cfg_all_mcast_i` set, every multicast address is accepted.
- R6: With `cfg_hash_en_i` set, a multicast address is accepted if and only if its hash bit is 1, unless another rule accepts it. The hash is computed as follows:
  - A reflected CRC-32 (polynomial 0xEDB88320) starts from all ones and runs over the six bytes, each byte taken least significant bit first.
  - The result is complemented and bit-reversed, and its top 6 bits form the index.
  - Index bit 5 picks `cfg_hash_hi_i` (1) or `cfg_hash_lo_i` (0), and index bits 4:0 pick the bit within that word.
- R7: A multicast address that is not broadcast is rejected when `cfg_promisc_i`, `cfg_all_mcast_i` and `cfg_hash_en_i` are all 0.
- R8: A unicast address is accepted only if it equals the MAC field of a valid table entry. That field holds the first received byte in bits 7:0 and the sixth byte in bits 47:40.
- R9: A table write stores the MAC and valid flag into entry `tbl_wr_idx_i` at the clock edge. A verdict computed in the same cycle as a write still uses the entry's previous contents.
- R10: A byte with `in_first_i` set is always treated as the first address byte, which discards any partial address. No `done_o` follows such a byte.
- R11: Cycles with `in_valid_i` low are ignored whatever `in_byte_i` holds, so gaps between bytes do not change the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | An address byte is present |
| in_first_i | input | 1 | This byte is the first address byte |
| in_byte_i | input | 8 | Address byte |
| cfg_promisc_i | input | 1 | Accept every frame |
| cfg_all_mcast_i | input | 1 | Accept every multicast frame |
| cfg_hash_en_i | input | 1 | Use hash table for multicast |
| cfg_hash_lo_i | input | 32 | Hash bins 0 to 31 |
| cfg_hash_hi_i | input | 32 | Hash bins 32 to 63 |
| tbl_wr_en_i | input | 1 | Write one unicast table entry |
| tbl_wr_idx_i | input | $clog2(NUM_ENTRIES) | Entry to write |
| tbl_wr_valid_i | input | 1 | Valid flag to store |
| tbl_wr_mac_i | input | 48 | Address to store, first byte in bits 7:0 |
| done_o | output | 1 | Verdict pulse |
| accept_o | output | 1 | Verdict, meaningful with done_o |

## Verification
A table write and a unicast comparison can fall in the same cycle when the write lands on the sixth address byte. The bench provokes this by writing the entry that holds the very address being sent, timed to that byte. It expects a reject, and it then resends the same address and expects an accept. A restart marker arriving in the middle of an address, followed at once by a full address, is also judged: exactly one verdict must come out, and it must belong to the second address.

// File: rtl/daf_pkg.sv
package daf_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * 8;
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_INIT = '1;
    localparam int HASH_IDX_W = 6;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] mac;
    } daf_entry_t;
endpackage

// File: rtl/daf_crc_byte.sv
module daf_crc_byte
    import daf_pkg::*;
(
    input  logic [CRC_W-1:0] crc_i,
    input  logic [7:0]       byte_i,
    output logic [CRC_W-1:0] crc_o
);
    logic [CRC_W-1:0] work;

    always_comb begin
        work = crc_i ^ {{(CRC_W-8){1'b0}}, byte_i};
        for (int b = 0; b < 8; b++) begin
            if (work[0]) work = (work >> 1) ^ CRC_POLY;
            else         work = work >> 1;
        end
        crc_o = work;
    end
endmodule

// File: rtl/daf_hash_pick.sv
module daf_hash_pick
    import daf_pkg::*;
(
    input  logic [CRC_W-1:0] crc_i,
    input  logic [31:0]      hash_lo_i,
    input  logic [31:0]      hash_hi_i,
    output logic             hit_o
);
    logic [CRC_W-1:0]      inv;
    logic [HASH_IDX_W-1:0] idx;
    logic [31:0]           word;

    always_comb begin
        inv = ~crc_i;
        // top bits of the reversed value are the low bits of inv, mirrored
        for (int k = 0; k < HASH_IDX_W; k++) idx[HASH_IDX_W-1-k] = inv[k];
        word  = idx[HASH_IDX_W-1] ? hash_hi_i : hash_lo_i;
        hit_o = word[idx[4:0]];
    end
endmodule

// File: rtl/daf_ucast_table.sv
module daf_ucast_table
    import daf_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           wr_en_i,
    input  logic [$clog2(NUM_ENTRIES)-1:0] wr_idx_i,
    input  logic                           wr_valid_i,
    input  logic [ADDR_W-1:0]              wr_mac_i,
    input  logic [ADDR_W-1:0]              cmp_mac_i,
    output logic                           hit_o
);
    localparam int IDX_W = $clog2(NUM_ENTRIES);

    logic [NUM_ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        daf_entry_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                ent_d.valid = wr_valid_i;
                ent_d.mac   = wr_mac_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) ent_q <= '0;
            else         ent_q <= ent_d;
        end

        assign hit_vec[g] = ent_q.valid && (ent_q.mac == cmp_mac_i);
    end

    assign hit_o = |hit_vec;
endmodule

// File: rtl/daf_filter.sv
module daf_filter
    import daf_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           in_valid_i,
    input  logic                           in_first_i,
    input  logic [7:0]                     in_byte_i,
    input  logic                           cfg_promisc_i,
    input  logic                           cfg_all_mcast_i,
    input  logic                           cfg_hash_en_i,
    input  logic [31:0]                    cfg_hash_lo_i,
    input  logic [31:0]                    cfg_hash_hi_i,
    input  logic                           tbl_wr_en_i,
    input  logic [$clog2(NUM_ENTRIES)-1:0] tbl_wr_idx_i,
    input  logic                           tbl_wr_valid_i,
    input  logic [ADDR_W-1:0]              tbl_wr_mac_i,
    output logic                           done_o,
    output logic                           accept_o
);
    localparam int CNT_W    = $clog2(ADDR_BYTES);
    localparam int LAST_IDX = ADDR_BYTES - 1;
    localparam int HELD_W   = ADDR_W - 8;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CRC_W-1:0]  crc;
        logic [HELD_W-1:0] mac;
        logic              done;
        logic              accept;
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0]  idx;
    logic              last_fire;
    logic [CRC_W-1:0]  crc_seed;
    logic [CRC_W-1:0]  crc_next;
    logic [ADDR_W-1:0] full_mac;
    logic              is_bcast;
    logic              is_mcast;
    logic              hash_hit;
    logic              ucast_hit;
    logic              verdict;

    always_comb begin
        idx       = in_first_i ? '0 : st_q.cnt;
        last_fire = in_valid_i && (idx == CNT_W'(LAST_IDX));
        crc_seed  = (idx == '0) ? CRC_INIT : st_q.crc;
        full_mac  = {in_byte_i, st_q.mac};
        is_bcast  = &full_mac;
        is_mcast  = full_mac[0];
    end

    daf_crc_byte u_crc (
        .crc_i  (crc_seed),
        .byte_i (in_byte_i),
        .crc_o  (crc_next)
    );

    daf_hash_pick u_hash (
        .crc_i     (crc_next),
        .hash_lo_i (cfg_hash_lo_i),
        .hash_hi_i (cfg_hash_hi_i),
        .hit_o     (hash_hit)
    );

    daf_ucast_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_tbl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (tbl_wr_en_i),
        .wr_idx_i   (tbl_wr_idx_i),
        .wr_valid_i (tbl_wr_valid_i),
        .wr_mac_i   (tbl_wr_mac_i),
        .cmp_mac_i  (full_mac),
        .hit_o      (ucast_hit)
    );

    always_comb begin
        if (cfg_promisc_i || is_bcast) verdict = 1'b1;
        else if (is_mcast)             verdict = cfg_all_mcast_i || (cfg_hash_en_i && hash_hit);
        else                           verdict = ucast_hit;
    end

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.accept = 1'b0;
        if (in_valid_i) begin
            st_d.crc = crc_next;
            if (last_fire) begin
                st_d.cnt    = '0;
                st_d.done   = 1'b1;
                st_d.accept = verdict;
            end else begin
                st_d.cnt = idx + CNT_W'(1);
                st_d.mac[int'(idx)*8 +: 8] = in_byte_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign done_o   = st_q.done;
    assign accept_o = st_q.accept;

    // R2
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R2
    accept_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> !accept_o);

    // R3
    promisc_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (last_fire && cfg_promisc_i) |=> (done_o && accept_o));

    // R7
    mcast_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (last_fire && !cfg_promisc_i && !cfg_all_mcast_i && !cfg_hash_en_i
         && is_mcast && !is_bcast) |=> (done_o && !accept_o));

    // R10
    restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_first_i) |=> !done_o);
endmodule

// File: tb/daf_filter_tb_top.sv
`timescale 1ns/1ps
module daf_filter_tb_top;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_first = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        promisc = 1'b0, all_mc = 1'b0, hash_en = 1'b0;
    logic [31:0] hash_lo = '0, hash_hi = '0;
    logic        wr_en = 1'b0, wr_valid = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [47:0] wr_mac = '0;
    logic        done, accept;

    int checks = 0;
    int fails  = 0;
    bit    exp_q[$];
    string tag_q[$];
    bit    prev_done = 1'b0;

    always #2.5 clk = ~clk;

    daf_filter #(.NUM_ENTRIES(N)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .in_valid_i(in_valid), .in_first_i(in_first), .in_byte_i(in_byte),
        .cfg_promisc_i(promisc), .cfg_all_mcast_i(all_mc), .cfg_hash_en_i(hash_en),
        .cfg_hash_lo_i(hash_lo), .cfg_hash_hi_i(hash_hi),
        .tbl_wr_en_i(wr_en), .tbl_wr_idx_i(wr_idx), .tbl_wr_valid_i(wr_valid),
        .tbl_wr_mac_i(wr_mac),
        .done_o(done), .accept_o(accept)
    );

    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] c, x, r;
        logic fb;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            fb = c[0] ^ a[k];
            c  = c >> 1;
            if (fb) c = c ^ 32'hEDB8_8320;
        end
        x = ~c;
        for (int i = 0; i < 32; i++) r[31-i] = x[i];
        return r[31:26];
    endfunction

    function automatic bit hbit(input logic [47:0] a);
        logic [5:0] i;
        i = hidx(a);
        return i[5] ? hash_hi[i[4:0]] : hash_lo[i[4:0]];
    endfunction

    task automatic idle();
        in_valid = 1'b0;
        in_first = 1'b0;
        in_byte  = 8'hA5 ^ in_byte;
        @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] b, input bit first);
        in_valid = 1'b1;
        in_first = first;
        in_byte  = b;
        @(negedge clk);
    endtask

    task automatic send(input logic [47:0] a, input bit exp, input string tag,
                        input int gap, input bit wr_last);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        for (int k = 0; k < 6; k++) begin
            if (wr_last && k == 5) wr_en = 1'b1;
            put_byte(a[8*k +: 8], k == 0);
            wr_en = 1'b0;
            if (k < 5) for (int g = 0; g < gap; g++) idle();
        end
        in_valid = 1'b0;
        in_first = 1'b0;
    endtask

    task automatic wr_entry(input int idx, input logic [47:0] m, input bit v);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_mac = m; wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                checks++;
                if (prev_done) begin
                    fails++;
                    $display("FAIL R2 done high two cycles: actual=1 expected=0");
                end
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R2 unexpected verdict: actual=%0d expected=none", accept);
                end else begin
                    bit e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (accept !== e) begin
                        fails++;
                        $display("FAIL %s accept: actual=%0d expected=%0d", t, accept, e);
                    end
                end
            end else if (accept) begin
                checks++;
                fails++;
                $display("FAIL R2 accept without done: actual=1 expected=0");
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [47:0] u1, u2, u3, u4, m1, mx;
        u1 = 48'h0605_0403_0200;
        u2 = 48'h55AA_1234_5678;
        u3 = 48'h0000_0000_00FE;
        u4 = 48'hC0DE_F00D_BE42;
        m1 = 48'h0000_005E_0001;

        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (done !== 1'b0 || accept !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs: actual=%0d%0d expected=00", done, accept);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R1 table empty after reset: unicast rejected
        send(u1, 1'b0, "R1", 0, 1'b0);

        wr_entry(0, u1, 1'b1);
        wr_entry(1, u2, 1'b1);
        wr_entry(2, u3, 1'b0);
        send(u1, 1'b1, "R8", 0, 1'b0);
        send(u2, 1'b1, "R8", 0, 1'b0);
        send(u3, 1'b0, "R8", 0, 1'b0);
        send(u4, 1'b0, "R8", 0, 1'b0);
        send(48'hFFFF_FFFF_FFFF, 1'b1, "R4", 0, 1'b0);
        send(m1, 1'b0, "R7", 0, 1'b0);

        all_mc = 1'b1;
        send(m1, 1'b1, "R5", 0, 1'b0);
        send(u4, 1'b0, "R5", 0, 1'b0);
        all_mc = 1'b0;

        hash_en = 1'b1;
        begin
            logic [5:0] i;
            i = hidx(m1);
            hash_lo = '0; hash_hi = '0;
            if (i[5]) hash_hi[i[4:0]] = 1'b1; else hash_lo[i[4:0]] = 1'b1;
            send(m1, 1'b1, "R6", 0, 1'b0);
            hash_lo = ~hash_lo; hash_hi = ~hash_hi;
            send(m1, 1'b0, "R6", 0, 1'b0);
        end
        hash_lo = 32'hA5C3_0F96;
        hash_hi = 32'h3C69_E1D2;
        for (int n = 0; n < 10; n++) begin
            mx = {8'(n * 37), 8'(n * 11 + 3), 8'hC4, 8'(n), 8'h9A, 8'(n * 2 + 1)} | 48'h1;
            send(mx, hbit(mx), "R6", 0, 1'b0);
        end
        hash_en = 1'b0;

        promisc = 1'b1;
        send(u4, 1'b1, "R3", 0, 1'b0);
        send(m1, 1'b1, "R3", 0, 1'b0);
        promisc = 1'b0;

        send(u1, 1'b1, "R11", 2, 1'b0);
        send(u4, 1'b0, "R11", 3, 1'b0);

        // R10 partial address then restart
        put_byte(u4[7:0], 1'b1);
        put_byte(u4[15:8], 1'b0);
        put_byte(u4[23:16], 1'b0);
        send(u1, 1'b1, "R10", 0, 1'b0);
        idle();

        // R9 write in the same cycle as the sixth byte
        wr_idx = 3'd3; wr_mac = u4; wr_valid = 1'b1;
        send(u4, 1'b0, "R9", 0, 1'b1);
        send(u4, 1'b1, "R9", 0, 1'b0);
        wr_entry(0, u1, 1'b0);
        send(u1, 1'b0, "R9", 0, 1'b0);

        repeat (4) idle();
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing verdicts: actual=%0d expected=0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule